// File: doc/BRIEF.md
# Synchronous Burst ROM Read Engine

This block is the device-side controller of a read-only memory that is read in bursts through a multiplexed address bus. On every rising clock edge it decodes a command from four active-low strobes. The commands load the mode settings, open a row, start a column read or cut a burst short. It keeps the open row address and the start column. It produces the burst address order in sequential or interleaved wrap. It returns each addressed word after a programmable column latency, in a 32-bit or a 16-bit organisation.

The memory contents are not stored. They are defined by an arithmetic function of the word index, so the bench can predict every word exactly. A host uses the block by loading the mode, activating a row, waiting the row latency and then issuing a column read. Words then appear one per enabled clock, for as many clocks as the burst length. A per-cycle mask blanks single words without moving the sequence. A clock-enable input freezes the whole engine for as long as it is low.

Top module: `sbrom_engine`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears dout_valid, dout and proto_err. It closes the row and sets the default mode: burst of 4, sequential order, column latency 3, row latency 1.
- R2: A command is taken only when cs_n is low at the edge. The encodings of {mrs_n,ras_n,cas_n} are: 011 mode load, 101 activate (addr is the row), 110 read (addr is the start column), 100 burst stop. Every other pattern, and any pattern with cs_n high, does nothing.
- R3: Mode load takes its fields from addr: bit 0 burst length (0 gives 4, 1 gives 8), bit 1 order (0 sequential, 1 interleaved), bits 3:2 column latency code c (latency 3+c), bit 4 row latency (0 gives 1, 1 gives 2).
- R4: An accepted read yields exactly burst-length words on consecutive enabled clocks, and then dout_valid stays low.
- R5: In sequential order, beat i addresses the start column with its low log2(BL) bits replaced by (start + i) mod BL.
- R6: In interleaved order, beat i addresses the start column with its low log2(BL) bits XORed with i.
- R7: For a read sampled at edge T, beat j is presented (dout_valid high) after edge T+CL+j, counting enabled edges only.
- R8: A read sampled fewer than RL enabled edges after the last activate, or with no row open since reset, is ignored: no words follow. proto_err is high for exactly the one cycle after that edge.
- R9: A burst stop sampled at an edge drops every pending word: dout_valid is low after that edge and stays low until a new read delivers data.
- R10: dqm high at the edge that would present beat j makes dout_valid and dout zero for that cycle. The following beats keep their addresses and their timing.
- R11: Word data: the index is i = row*256 + column when narrow_n was high at the read (32-bit mode, column is addr[7:0]), and D(i) = (i*0x9E3779B1 mod 2^32) XOR 0x0F0F5A5A. When narrow_n was low (16-bit mode, column is addr[8:0]), dout = {16'h0, half} where half is the low 16 bits of D(row*256 + column/2) for an even column and the high 16 bits for an odd one.
- R12: While cke is low at an edge, commands are ignored and the outputs, the burst position, the latency pipeline and the row-latency count all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the engine |
| cs_n | input | 1 | Active-low select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| mrs_n | input | 1 | Active-low mode-load strobe |
| narrow_n | input | 1 | Organisation at read: low 16-bit, high 32-bit |
| addr | input | 13 | Shared row / column / mode bus |
| dqm | input | 1 | Output mask for the word presented at this edge |
| dout | output | 32 | Read data (upper half zero in 16-bit mode) |
| dout_valid | output | 1 | dout carries a burst word this cycle |
| proto_err | output | 1 | One-cycle flag for a rejected early read |

## Verification
An error in the wrap logic shows up as a wrong word during the burst, starting at the first beat whose low bits carry past the block boundary. So the table starts bursts at unaligned columns in both orders. An off-by-one in the latency pipeline or the beat counter moves dout_valid by one clock at the start or end of the burst, and that shows within CL+BL clocks of the read. A row-latency counter that is not reset, or that decrements too early, turns a rejected read into data. A stop or mask that is not applied leaves dout_valid high in a cycle where the bench expects it low. A freeze that leaks shifts every later beat by the number of frozen clocks.

// File: rtl/sbrom_pkg.sv
package sbrom_pkg;

  localparam int CL_MAX = 6;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_MODE,
    CMD_ACT,
    CMD_READ,
    CMD_STOP
  } cmd_e;

  typedef struct packed {
    logic       bl8;
    logic       ilv;
    logic [1:0] cl_code;
    logic       rl2;
  } mode_t;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic mrs_n,
                                      input logic ras_n, input logic cas_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n) begin
      case ({mrs_n, ras_n, cas_n})
        3'b011:  c = CMD_MODE;
        3'b101:  c = CMD_ACT;
        3'b110:  c = CMD_READ;
        3'b100:  c = CMD_STOP;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

  // low three column bits of one beat; bit 2 kept for a burst of four
  function automatic logic [2:0] wrap_low(input logic [2:0] start, input logic [2:0] beat,
                                         input logic bl8, input logic ilv);
    logic [2:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    if (!bl8) r[2] = start[2];
    return r;
  endfunction

  // pipeline stage that is one clock before presentation
  function automatic logic [2:0] tap_index(input logic [1:0] cl_code);
    return {1'b0, cl_code} + 3'd1;
  endfunction

  function automatic logic [31:0] rom_dword(input logic [31:0] idx);
    return (idx * 32'h9E37_79B1) ^ 32'h0F0F_5A5A;
  endfunction

endpackage

// File: rtl/sbrom_cmd_decode.sv
module sbrom_cmd_decode import sbrom_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              mrs_n,
  input  logic              narrow_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              read_go,
  output logic              stop_go,
  output logic              bl8,
  output logic              ilv,
  output logic [1:0]        cl_code,
  output logic [ADDR_W-1:0] row,
  output logic [COL_W:0]    col_start,
  output logic              n16,
  output logic              proto_err
);

  cmd_e              cmd;
  mode_t             mode_q;
  logic              row_open;
  logic              rl_wait;
  logic              err_q;
  logic [ADDR_W-1:0] row_q;
  logic              rd_req;
  logic              rd_bad;

  always_comb begin
    cmd       = decode_cmd(cs_n, mrs_n, ras_n, cas_n);
    rd_req    = cke && (cmd == CMD_READ);
    read_go   = rd_req && row_open && !rl_wait;
    rd_bad    = rd_req && !(row_open && !rl_wait);
    stop_go   = cke && (cmd == CMD_STOP);
    n16       = !narrow_n;
    col_start = n16 ? addr[COL_W:0] : {1'b0, addr[COL_W-1:0]};
    bl8       = mode_q.bl8;
    ilv       = mode_q.ilv;
    cl_code   = mode_q.cl_code;
    row       = row_q;
    proto_err = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      row_open <= 1'b0;
      rl_wait  <= 1'b0;
      err_q    <= 1'b0;
      row_q    <= '0;
    end else if (cke) begin
      err_q <= rd_bad;
      if (cmd == CMD_MODE) begin
        mode_q.bl8     <= addr[0];
        mode_q.ilv     <= addr[1];
        mode_q.cl_code <= addr[3:2];
        mode_q.rl2     <= addr[4];
      end
      if (cmd == CMD_ACT) begin
        row_open <= 1'b1;
        row_q    <= addr;
        rl_wait  <= mode_q.rl2;
      end else if (rl_wait) begin
        rl_wait <= 1'b0;
      end
    end
  end

  // R3: mode fields change only on an enabled mode load
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cke && cmd == CMD_MODE) |=> $stable(mode_q));

  // R8: with row latency 2 the clock after an activate accepts no read
  p_rl2_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd == CMD_ACT && mode_q.rl2) |=> !read_go);

endmodule

// File: rtl/sbrom_burst_gen.sv
module sbrom_burst_gen import sbrom_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              read_go,
  input  logic              stop_go,
  input  logic              bl8,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] row,
  input  logic [COL_W:0]    col_start,
  input  logic              n16,
  output logic              issue_v,
  output logic [ADDR_W-1:0] issue_row,
  output logic [COL_W:0]    issue_col,
  output logic              issue_n16
);

  logic              active;
  logic [2:0]        beat;
  logic [ADDR_W-1:0] s_row;
  logic [COL_W:0]    s_col;
  logic              s_n16;
  logic              s_bl8;
  logic              s_ilv;
  logic              issue_last;

  always_comb begin
    issue_last = (beat == {s_bl8, 2'b11});
    issue_v    = active;
    issue_row  = s_row;
    issue_n16  = s_n16;
    issue_col  = {s_col[COL_W:3], wrap_low(s_col[2:0], beat, s_bl8, s_ilv)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      s_row  <= '0;
      s_col  <= '0;
      s_n16  <= 1'b0;
      s_bl8  <= 1'b0;
      s_ilv  <= 1'b0;
    end else if (cke) begin
      if (stop_go) begin
        active <= 1'b0;
      end else if (read_go) begin
        active <= 1'b1;
        beat   <= '0;
        s_row  <= row;
        s_col  <= col_start;
        s_n16  <= n16;
        s_bl8  <= bl8;
        s_ilv  <= ilv;
      end else if (active) begin
        if (issue_last) active <= 1'b0;
        else            beat   <= beat + 3'd1;
      end
    end
  end

  // R4: a burst of four never reaches beat four
  p_beat_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !s_bl8) |-> !beat[2]);

  // R4: issue stops after the last beat unless a new read arrives
  p_burst_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && active && issue_last && !read_go) |=> !issue_v);

endmodule

// File: rtl/sbrom_lat_pipe.sv
module sbrom_lat_pipe import sbrom_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              stop_go,
  input  logic              dqm,
  input  logic [1:0]        cl_code,
  input  logic              in_v,
  input  logic [ADDR_W-1:0] in_row,
  input  logic [COL_W:0]    in_col,
  input  logic              in_n16,
  output logic [31:0]       dout,
  output logic              dout_valid
);

  localparam int DEPTH = CL_MAX - 1;
  localparam int SW    = ADDR_W + COL_W + 2;
  localparam int IW    = ADDR_W + COL_W;

  logic [DEPTH-1:0]  st_v;
  logic [SW-1:0]     st_d [DEPTH];
  logic [2:0]        tap;
  logic              tap_v;
  logic              t_n16;
  logic [ADDR_W-1:0] t_row;
  logic [COL_W:0]    t_col;
  logic [IW-1:0]     idx;
  logic [31:0]       dw;
  logic [31:0]       word;

  always_comb begin
    tap   = tap_index(cl_code);
    tap_v = st_v[tap];
    {t_n16, t_row, t_col} = st_d[tap];
    idx   = t_n16 ? {t_row, t_col[COL_W:1]} : {t_row, t_col[COL_W-1:0]};
    dw    = rom_dword(32'(idx));
    if (t_n16) word = {16'h0000, t_col[0] ? dw[31:16] : dw[15:0]};
    else       word = dw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v       <= '0;
      for (int k = 0; k < DEPTH; k++) st_d[k] <= '0;
      dout       <= '0;
      dout_valid <= 1'b0;
    end else if (cke) begin
      st_v     <= stop_go ? '0 : {st_v[DEPTH-2:0], in_v};
      st_d[0]  <= {in_n16, in_row, in_col};
      for (int k = 1; k < DEPTH; k++) st_d[k] <= st_d[k-1];
      if (stop_go || !tap_v || dqm) begin
        dout_valid <= 1'b0;
        dout       <= '0;
      end else begin
        dout_valid <= 1'b1;
        dout       <= word;
      end
    end
  end

  // R10: a masked presentation edge leaves no word on the outputs
  p_mask_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && dqm) |=> (!dout_valid && dout == '0));

  // R12: outputs hold while the clock enable is low
  p_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(dout) && $stable(dout_valid)));

endmodule

// File: rtl/sbrom_engine.sv
module sbrom_engine import sbrom_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              mrs_n,
  input  logic              narrow_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  output logic [31:0]       dout,
  output logic              dout_valid,
  output logic              proto_err
);

  logic              read_go;
  logic              stop_go;
  logic              bl8;
  logic              ilv;
  logic [1:0]        cl_code;
  logic [ADDR_W-1:0] row;
  logic [COL_W:0]    col_start;
  logic              n16;
  logic              issue_v;
  logic [ADDR_W-1:0] issue_row;
  logic [COL_W:0]    issue_col;
  logic              issue_n16;

  sbrom_cmd_decode #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .mrs_n(mrs_n), .narrow_n(narrow_n), .addr(addr),
    .read_go(read_go), .stop_go(stop_go), .bl8(bl8), .ilv(ilv),
    .cl_code(cl_code), .row(row), .col_start(col_start), .n16(n16),
    .proto_err(proto_err)
  );

  sbrom_burst_gen #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .cke(cke), .read_go(read_go),
    .stop_go(stop_go), .bl8(bl8), .ilv(ilv), .row(row),
    .col_start(col_start), .n16(n16), .issue_v(issue_v),
    .issue_row(issue_row), .issue_col(issue_col), .issue_n16(issue_n16)
  );

  sbrom_lat_pipe #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .cke(cke), .stop_go(stop_go), .dqm(dqm),
    .cl_code(cl_code), .in_v(issue_v), .in_row(issue_row),
    .in_col(issue_col), .in_n16(issue_n16), .dout(dout),
    .dout_valid(dout_valid)
  );

  // R9: nothing is presented right after an accepted stop
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |=> !dout_valid);

  // R4: an accepted read starts issuing beats on the next cycle
  p_read_issues_r4: assert property (@(posedge clk) disable iff (!rst_n)
    read_go |=> issue_v);

endmodule

// File: tb/test_sbrom_engine.sv
module test_sbrom_engine;
  localparam int CLK_P = 10;
  localparam int COLS  = 256;

  // {row[27:15], col[14:6], n16[5], rl2[4], cl[3:2], ilv[1], bl8[0]}
  localparam logic [27:0] VEC [16] = '{
    {13'd1,    9'd0,   1'b0, 1'b0, 2'd0, 1'b0, 1'b0},
    {13'd2,    9'd5,   1'b0, 1'b1, 2'd0, 1'b0, 1'b1},
    {13'd3,    9'd6,   1'b1, 1'b0, 2'd0, 1'b1, 1'b0},
    {13'd4,    9'd3,   1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
    {13'd5,    9'd13,  1'b0, 1'b1, 2'd1, 1'b0, 1'b0},
    {13'd6,    9'd301, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1},
    {13'd7,    9'd2,   1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
    {13'd8,    9'd255, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1},
    {13'd100,  9'd7,   1'b0, 1'b0, 2'd2, 1'b0, 1'b0},
    {13'd8191, 9'd250, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1},
    {13'd11,   9'd511, 1'b1, 1'b1, 2'd2, 1'b1, 1'b0},
    {13'd12,   9'd44,  1'b0, 1'b0, 2'd2, 1'b1, 1'b1},
    {13'd13,   9'd1,   1'b0, 1'b0, 2'd3, 1'b0, 1'b0},
    {13'd14,   9'd77,  1'b1, 1'b1, 2'd3, 1'b0, 1'b1},
    {13'd15,   9'd6,   1'b0, 1'b0, 2'd3, 1'b1, 1'b0},
    {13'd4096, 9'd129, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1;
  logic        ras_n = 1'b1;
  logic        cas_n = 1'b1;
  logic        mrs_n = 1'b1;
  logic        narrow_n = 1'b1;
  logic        dqm = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] dout;
  logic        dout_valid;
  logic        proto_err;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sbrom_engine i_sbrom_engine (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .mrs_n(mrs_n), .narrow_n(narrow_n), .addr(addr),
    .dqm(dqm), .dout(dout), .dout_valid(dout_valid), .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 nop, 1 mode, 2 activate, 3 read, 4 stop; one clock per call
  task automatic step(input int c, input logic [12:0] a);
    cs_n = (c == 0);
    {mrs_n, ras_n, cas_n} = (c == 1) ? 3'b011 : (c == 2) ? 3'b101 :
                            (c == 3) ? 3'b110 : (c == 4) ? 3'b100 : 3'b111;
    addr = a;
    @(negedge clk);
  endtask

  function automatic int exp_col(input int col, input int i, input int bl, input bit ilv);
    int base;
    int off;
    base = col - (col % bl);
    off  = col % bl;
    return ilv ? base + (off ^ i) : base + ((off + i) % bl);
  endfunction

  function automatic logic [31:0] exp_word(input int row, input int col, input bit n16);
    logic [31:0] i;
    logic [31:0] d;
    i = n16 ? row * COLS + col / 2 : row * COLS + col;
    d = (i * 32'h9E3779B1) ^ 32'h0F0F5A5A;
    if (!n16) return d;
    return (col % 2) ? {16'h0, d[31:16]} : {16'h0, d[15:0]};
  endfunction

  task automatic expect_burst(input int row, input int col, input int bl, input bit ilv,
                              input int cl, input bit n16, input int mask_beat);
    for (int k = 1; k <= cl + bl + 1; k++) begin
      int j;
      logic [31:0] e;
      j = k - cl;
      dqm = (mask_beat >= 0 && j == mask_beat);
      step(0, '0);
      dqm = 1'b0;
      if (j >= 0 && j < bl) begin
        e = exp_word(row, exp_col(col, j, bl, ilv), n16);
        if (j == mask_beat) begin
          check(!dout_valid && dout == '0, "R10 masked beat", {dout_valid, dout[30:0]}, 32'h0);
        end else begin
          check(dout_valid, "R7 R3 word present at T+CL+j", {31'h0, dout_valid}, 32'h1);
          check(dout == e, n16 ? "R11 16-bit word" : (ilv ? "R6 interleaved word" : "R5 sequential word"),
                dout, e);
        end
      end else begin
        check(!dout_valid, "R4 no word outside the burst", {31'h0, dout_valid}, 32'h0);
      end
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!dout_valid && !proto_err && dout == '0, "R1 reset state",
          {dout_valid, proto_err, dout[29:0]}, 32'h0);

    // R8: read with no open row
    step(3, 13'd0);
    check(proto_err, "R8 read without row flags", {31'h0, proto_err}, 32'h1);
    step(0, '0);
    check(!proto_err && !dout_valid, "R8 flag is one cycle", {30'h0, proto_err, dout_valid}, 32'h0);

    // R1: default mode BL4 sequential CL3 RL1
    step(2, 13'd1);
    step(3, 13'd4);
    check(!proto_err, "R1 default row latency 1", {31'h0, proto_err}, 32'h0);
    expect_burst(1, 4, 4, 1'b0, 3, 1'b0, -1);

    // table over burst length, order and column latency
    for (int v = 0; v < 16; v++) begin
      logic [27:0] t;
      int bl;
      int cl;
      t  = VEC[v];
      bl = t[0] ? 8 : 4;
      cl = 3 + int'(t[3:2]);
      step(1, {8'h0, t[4:0]});
      step(2, t[27:15]);
      if (t[4]) step(0, '0);
      narrow_n = !t[5];
      step(3, {4'h0, t[14:6]});
      check(!proto_err, "R8 read after row latency accepted", {31'h0, proto_err}, 32'h0);
      expect_burst(int'(t[27:15]), t[5] ? int'(t[14:6]) : int'(t[13:6]), bl, t[1], cl, t[5], -1);
      narrow_n = 1'b1;
    end

    // R8: early read with row latency 2
    step(1, 13'h10);
    step(2, 13'd2);
    step(3, 13'd5);
    check(proto_err, "R8 early read flags", {31'h0, proto_err}, 32'h1);
    for (int k = 0; k < 9; k++) begin
      step(0, '0);
      check(!dout_valid && !proto_err, "R8 early read ignored", {30'h0, proto_err, dout_valid}, 32'h0);
    end

    // R9: burst stop after two words
    step(1, 13'h01);
    step(2, 13'd7);
    step(3, 13'd16);
    for (int k = 1; k <= 4; k++) begin
      step(0, '0);
      if (k >= 3) check(dout_valid && dout == exp_word(7, 16 + k - 3, 1'b0),
                        "R9 words before stop", dout, exp_word(7, 16 + k - 3, 1'b0));
    end
    step(4, '0);
    check(!dout_valid, "R9 stop silences at once", {31'h0, dout_valid}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      step(0, '0);
      check(!dout_valid, "R9 no word after stop", {31'h0, dout_valid}, 32'h0);
    end

    // R10: mask beat 1 of interleaved BL4 CL4
    step(1, 13'h06);
    step(2, 13'd3);
    step(3, 13'd9);
    expect_burst(3, 9, 4, 1'b1, 4, 1'b0, 1);

    // R12: freeze after the first word with a stop on the strobes
    step(1, 13'h00);
    step(2, 13'd9);
    step(3, 13'd2);
    for (int k = 1; k <= 3; k++) step(0, '0);
    check(dout_valid && dout == exp_word(9, 2, 1'b0), "R12 first word before freeze",
          dout, exp_word(9, 2, 1'b0));
    cke = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(4, '0);
      check(dout_valid && dout == exp_word(9, 2, 1'b0), "R12 outputs frozen",
            dout, exp_word(9, 2, 1'b0));
    end
    cke = 1'b1;
    for (int j = 1; j < 4; j++) begin
      step(0, '0);
      check(dout_valid && dout == exp_word(9, exp_col(2, j, 4, 1'b0), 1'b0),
            "R12 burst resumes after freeze", dout, exp_word(9, exp_col(2, j, 4, 1'b0), 1'b0));
    end
    step(0, '0);
    check(!dout_valid, "R12 burst ends after resume", {31'h0, dout_valid}, 32'h0);

    // R2: read pattern with cs_n high does nothing
    cs_n = 1'b1;
    {mrs_n, ras_n, cas_n} = 3'b110;
    addr = 13'd3;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      step(0, '0);
      check(!dout_valid && !proto_err, "R2 deselected read ignored",
            {30'h0, proto_err, dout_valid}, 32'h0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule